// File: doc/BRIEF.md
# Serial Configuration Register Receiver

This block is a write-only slave on a two-wire serial bus. It loads the configuration registers of a clock fan-out buffer. The bus lines are first brought into the system clock domain. Start and stop conditions are then detected on the synchronized lines. Bytes are assembled most significant bit first. A write is accepted only when its first byte equals the fixed address `8'hD2`, which is seven address bits with a direction bit of 0.

After a matching address, two more bytes arrive. These are a command byte and a count byte, and both are received and thrown away. The next seven bytes fill configuration registers 0 to 6 by position. The registers are presented as one flat parallel bus. The block also produces an output-enable vector that gates each buffered output by the enable pin and by one register bit.

Top module: `cfg_serial_rx`

States: `ST_IDLE` (bus free), `ST_SHIFT` (collecting bits), `ST_ACK_WAIT` (byte complete, waiting for SCL to fall), `ST_ACK_DRIVE` (holding SDA low for the acknowledge clock), `ST_IGNORE` (address mismatch, silent).

Transitions:
- Any state goes to `ST_SHIFT` on a start or repeated start.
- Any state goes to `ST_IDLE` on a stop.
- `ST_SHIFT` goes to `ST_ACK_WAIT` after the eighth bit of an accepted byte.
- `ST_SHIFT` goes to `ST_IGNORE` after the eighth bit of a first byte that does not match.
- `ST_ACK_WAIT` goes to `ST_ACK_DRIVE` on an SCL fall.
- `ST_ACK_DRIVE` goes to `ST_SHIFT` on the next SCL fall.

## Requirements
- R1: While reset is asserted and after it is released, all seven registers hold `8'hFF` and `sda_pull` is 0.
- R2: A transaction whose first byte is `8'hD2`, followed by a command byte, a count byte and seven data bytes, loads data byte k into register k. Register k is `cfg_regs[8k+7:8k]`.
- R3: If the first byte after a start differs from `8'hD2`, no register changes and no acknowledge is given for that byte or for any later byte, up to the next start. This holds even if a later byte equals `8'hD2`.
- R4: The values of the command byte and the count byte have no effect on any register.
- R5: Bits are taken on SCL rising edges, most significant bit first.
- R6: A stop or a repeated start before the tenth byte ends the transaction. Registers already loaded keep their new values. The next transaction starts again at the address byte and then register 0.
- R7: Bytes after the tenth byte of a matching transaction are acknowledged and change no register.
- R8: `out_en[i]` equals `oe_pin` AND bit `i%8` of register `i/8`. When `oe_pin` is 0, all of `out_en` is 0.
- R9: Every byte of a matching transaction is acknowledged. `sda_pull` goes to 1 on the SCL fall after the eighth bit and back to 0 on the following SCL fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| oe_pin | input | 1 | Global output enable pin |
| sda_pull | output | 1 | When 1, the pad pulls SDA low (acknowledge) |
| cfg_regs | output | 8*NUM_DATA | Configuration registers; register k at bits [8k+7:8k] |
| out_en | output | NUM_OUT | Per-output enable, gated by pin and register bits |

## Verification
The bench covers several cases, each of which catches a specific fault:
- An address that differs only in the direction bit. A comparison that skipped that bit would acknowledge the address and load the registers.
- A mismatched transaction in which the address value appears later in the same transfer. A design that kept looking for the address would wake up on it.
- Early stops, repeated starts and bytes beyond the tenth. These expose a byte position counter that is not reset, or one that wraps around and overwrites register 0.
- Data patterns `8'h80` against `8'h01`. These catch a design that shifts least significant bit first.
- Acknowledge samples taken in the middle of the ninth SCL high phase. These catch a pull that starts or ends on the wrong clock edge.

// File: rtl/cfg_rx_pkg.sv
package cfg_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_ACK_WAIT,
        ST_ACK_DRIVE,
        ST_IGNORE
    } link_state_t;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/cfg_line_sync.sv
module cfg_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;

    // The idle bus is high, so every stage resets to 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[STAGES-2:0], scl_in};
            sda_chain <= {sda_chain[STAGES-2:0], sda_in};
            scl_q     <= scl_chain[STAGES-1];
            sda_q     <= sda_chain[STAGES-1];
        end
    end

    assign scl_s     = scl_chain[STAGES-1];
    assign sda_s     = sda_chain[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    // A data edge counts as a bus condition only when SCL is high on both sides of it.
    assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/cfg_link_fsm.sv
module cfg_link_fsm
    import cfg_rx_pkg::*;
#(
    parameter logic [7:0] ADDR     = 8'hD2,
    parameter int         NUM_DATA = 7,
    parameter int         IDX_W    = $clog2(NUM_DATA + 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    output link_state_t       state,
    output logic              sda_pull,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data
);

    localparam int FIRST_DATA = 3;
    localparam int TOTAL      = NUM_DATA + FIRST_DATA;

    link_state_t       nxt;
    logic [2:0]        bit_cnt;
    logic [6:0]        shreg;
    logic [IDX_W-1:0]  byte_idx;
    logic              byte_done;
    logic [7:0]        full_byte;
    logic              pull_q;

    assign full_byte = {shreg, sda_s};
    assign byte_done = (state == ST_SHIFT) && scl_rise && (bit_cnt == 3'd7);

    // State register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            byte_idx <= '0;
            pull_q   <= 1'b0;
        end else begin
            state  <= nxt;
            pull_q <= (nxt == ST_ACK_DRIVE);
            if (start_evt || stop_evt) begin
                bit_cnt  <= '0;
                shreg    <= '0;
                byte_idx <= '0;
            end else if (state == ST_SHIFT && scl_rise) begin
                shreg   <= full_byte[6:0];
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7 && byte_idx != IDX_W'(TOTAL))
                    byte_idx <= byte_idx + 1'b1;
            end
        end
    end

    // Next state and outputs
    always_comb begin
        nxt     = state;
        wr_en   = 1'b0;
        wr_idx  = byte_idx - IDX_W'(FIRST_DATA);
        wr_data = full_byte;
        if (start_evt) begin
            nxt = ST_SHIFT;
        end else if (stop_evt) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_SHIFT: begin
                    if (byte_done) begin
                        if (byte_idx == '0 && full_byte != ADDR)
                            nxt = ST_IGNORE;
                        else
                            nxt = ST_ACK_WAIT;
                        wr_en = (byte_idx >= IDX_W'(FIRST_DATA)) &&
                                (byte_idx <  IDX_W'(TOTAL));
                    end
                end
                ST_ACK_WAIT:  if (scl_fall) nxt = ST_ACK_DRIVE;
                ST_ACK_DRIVE: if (scl_fall) nxt = ST_SHIFT;
                ST_IGNORE:    nxt = ST_IGNORE;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    assign sda_pull = pull_q;

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_rx_pkg::*;
#(
    parameter int          NUM_DATA  = 7,
    parameter int          IDX_W     = $clog2(NUM_DATA + 4),
    parameter logic [7:0]  RESET_VAL = 8'hFF
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [BYTE_W-1:0]            wr_data,
    output logic [BYTE_W*NUM_DATA-1:0]   regs_flat
);

    for (genvar k = 0; k < NUM_DATA; k++) begin : g_reg
        logic [BYTE_W-1:0] r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                r <= RESET_VAL;
            else if (wr_en && wr_idx == IDX_W'(k))
                r <= wr_data;
        end
        assign regs_flat[BYTE_W*k +: BYTE_W] = r;
    end

endmodule

// File: rtl/cfg_out_gate.sv
module cfg_out_gate #(
    parameter int NUM_OUT = 16,
    parameter int CFG_W   = 56
) (
    input  logic               oe_pin,
    input  logic [CFG_W-1:0]   cfg_flat,
    output logic [NUM_OUT-1:0] out_en
);

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_gate
        assign out_en[i] = oe_pin & cfg_flat[i];
    end

endmodule

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx
    import cfg_rx_pkg::*;
#(
    parameter logic [7:0] ADDR        = 8'hD2,
    parameter int         NUM_DATA    = 7,
    parameter int         NUM_OUT     = 16,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        scl_in,
    input  logic                        sda_in,
    input  logic                        oe_pin,
    output logic                        sda_pull,
    output logic [8*NUM_DATA-1:0]       cfg_regs,
    output logic [NUM_OUT-1:0]          out_en
);

    localparam int IDX_W = $clog2(NUM_DATA + 4);

    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_evt;
    logic              stop_evt;
    link_state_t       state;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [7:0]        wr_data;

    cfg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    cfg_link_fsm #(.ADDR(ADDR), .NUM_DATA(NUM_DATA), .IDX_W(IDX_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .state     (state),
        .sda_pull  (sda_pull),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    cfg_reg_bank #(.NUM_DATA(NUM_DATA), .IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .regs_flat (cfg_regs)
    );

    cfg_out_gate #(.NUM_OUT(NUM_OUT), .CFG_W(8*NUM_DATA)) u_gate (
        .oe_pin    (oe_pin),
        .cfg_flat  (cfg_regs),
        .out_en    (out_en)
    );

endmodule

// File: rtl/cfg_serial_rx_chk.sv
module cfg_serial_rx_chk
    import cfg_rx_pkg::*;
#(
    parameter int NUM_DATA = 7,
    parameter int NUM_OUT  = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    scl_rise,
    input logic                    scl_fall,
    input logic                    start_evt,
    input logic                    stop_evt,
    input link_state_t             state,
    input logic                    sda_pull,
    input logic                    oe_pin,
    input logic [8*NUM_DATA-1:0]   cfg_regs,
    input logic [NUM_OUT-1:0]      out_en
);

    logic [NUM_DATA-1:0] chg;
    logic [8*NUM_DATA-1:0] regs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '1;
        else        regs_q <= cfg_regs;
    end

    for (genvar k = 0; k < NUM_DATA; k++) begin : g_chg
        assign chg[k] = (cfg_regs[8*k +: 8] != regs_q[8*k +: 8]);
    end

    // R2: register contents move only on the cycle after a sampled SCL rise
    a_r2_write_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_regs) |-> $past(scl_rise));

    // R2: a single byte lands per write
    a_r2_one_reg_per_write: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(chg) <= 1);

    // R3: an ignored transfer leaves the registers alone
    a_r3_ignore_holds_regs: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE && $past(state == ST_IGNORE)) |-> $stable(cfg_regs));

    // R9: the acknowledge pull begins after an SCL fall
    a_r9_ack_starts_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> $past(scl_fall));

    // R9: the pull ends after an SCL fall or a bus condition
    a_r9_ack_ends_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull) |-> $past(scl_fall || start_evt || stop_evt));

    // R8: the enable pin low silences every output
    a_r8_pin_off: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_pin |-> (out_en == '0));

    // R8: no output is enabled without its register bit
    a_r8_subset: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(out_en) <= $countones(cfg_regs[NUM_OUT-1:0]));

endmodule

bind cfg_serial_rx cfg_serial_rx_chk #(.NUM_DATA(NUM_DATA), .NUM_OUT(NUM_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .state     (state),
    .sda_pull  (sda_pull),
    .oe_pin    (oe_pin),
    .cfg_regs  (cfg_regs),
    .out_en    (out_en)
);

// File: tb/cfg_serial_rx_bench.sv
`timescale 1ns/1ps
module cfg_serial_rx_bench;

    localparam int HP = 8;
    localparam int ND = 7;
    localparam int NO = 16;

    // {expect_match, address, command, count, data0 .. data6}
    localparam logic [80:0] VEC [4] = '{
        {1'b1, 8'hD2, 8'hA5, 8'h07, 8'h80, 8'h01, 8'h3C, 8'hC3, 8'h00, 8'hFF, 8'h5A},
        {1'b0, 8'hD3, 8'h00, 8'h07, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
        {1'b0, 8'h52, 8'hD2, 8'h07, 8'h11, 8'h11, 8'h11, 8'h11, 8'h11, 8'h11, 8'h11},
        {1'b1, 8'hD2, 8'hFF, 8'h00, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC, 8'hDE}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic oe_pin = 1'b1;
    logic sda_pull;
    logic [8*ND-1:0] cfg_regs;
    logic [NO-1:0] out_en;
    logic sda_line;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [7:0] exp_r [ND];

    assign sda_line = m_sda & ~sda_pull;

    always #4 clk = ~clk;

    cfg_serial_rx u_cfg_serial_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (m_scl),
        .sda_in   (sda_line),
        .oe_pin   (oe_pin),
        .sda_pull (sda_pull),
        .cfg_regs (cfg_regs),
        .out_en   (out_en)
    );

    task automatic wait_c(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [8*ND-1:0] exp_flat();
        logic [8*ND-1:0] f;
        for (int k = 0; k < ND; k++) f[8*k +: 8] = exp_r[k];
        return f;
    endfunction

    task automatic bus_start();
        m_sda = 1'b1; wait_c(HP);
        m_scl = 1'b1; wait_c(HP);
        m_sda = 1'b0; wait_c(HP);
        m_scl = 1'b0; wait_c(2);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_c(HP);
        m_scl = 1'b1; wait_c(HP);
        m_sda = 1'b1; wait_c(HP);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wait_c(HP);
            m_scl = 1'b1; wait_c(HP);
            m_scl = 1'b0; wait_c(2);
        end
        m_sda = 1'b1; wait_c(HP);
        m_scl = 1'b1; wait_c(HP/2);
        ack = sda_pull;
        wait_c(HP/2);
        m_scl = 1'b0; wait_c(2);
    endtask

    task automatic send_expect(input logic [7:0] b, input logic exp_ack, input string tag);
        logic a;
        send_byte(b, a);
        chk(a == exp_ack, tag, 64'(a), 64'(exp_ack));
    endtask

    initial begin
        wait_c(5);
        // R1: reset state
        chk(cfg_regs == '1, "R1 regs during reset", 64'(cfg_regs), 64'(56'hFFFFFFFFFFFFFF));
        chk(sda_pull == 1'b0, "R1 pull during reset", 64'(sda_pull), 64'd0);
        rst_n = 1'b1;
        wait_c(5);
        for (int k = 0; k < ND; k++) exp_r[k] = 8'hFF;
        chk(cfg_regs == exp_flat(), "R1 regs after reset", 64'(cfg_regs), 64'(exp_flat()));

        // Table walk: R2 R3 R4 R5 R9
        for (int v = 0; v < 4; v++) begin
            logic m;
            m = VEC[v][80];
            bus_start();
            for (int b = 0; b < 10; b++)
                send_expect(VEC[v][79-8*b -: 8], m, m ? "R9 ack on match" : "R3 no ack on mismatch");
            bus_stop();
            if (m)
                for (int k = 0; k < ND; k++) exp_r[k] = VEC[v][55-8*k -: 8];
            chk(cfg_regs == exp_flat(), "R2 R4 R5 table regs", 64'(cfg_regs), 64'(exp_flat()));
        end

        // R3: silent after mismatch even when the address value appears later
        bus_start();
        send_expect(8'h90, 1'b0, "R3 mismatch addr");
        send_expect(8'hD2, 1'b0, "R3 later addr ignored");
        send_expect(8'h00, 1'b0, "R3 filler ignored");
        send_expect(8'h00, 1'b0, "R3 filler ignored");
        send_expect(8'h66, 1'b0, "R3 data ignored");
        chk(cfg_regs == exp_flat(), "R3 regs kept", 64'(cfg_regs), 64'(exp_flat()));
        bus_start();
        send_expect(8'hD2, 1'b1, "R3 new start accepted");
        send_expect(8'h00, 1'b1, "R9 cmd ack");
        send_expect(8'h00, 1'b1, "R9 count ack");
        send_expect(8'h77, 1'b1, "R9 data ack");
        bus_stop();
        exp_r[0] = 8'h77;
        chk(cfg_regs == exp_flat(), "R3 load after new start", 64'(cfg_regs), 64'(exp_flat()));

        // R6: early stop keeps partial writes
        bus_start();
        send_expect(8'hD2, 1'b1, "R6 addr");
        send_expect(8'h01, 1'b1, "R6 cmd");
        send_expect(8'h02, 1'b1, "R6 count");
        send_expect(8'h11, 1'b1, "R6 d0");
        send_expect(8'h22, 1'b1, "R6 d1");
        bus_stop();
        exp_r[0] = 8'h11; exp_r[1] = 8'h22;
        chk(cfg_regs == exp_flat(), "R6 early stop", 64'(cfg_regs), 64'(exp_flat()));

        // R6: repeated start restarts at the address byte
        bus_start();
        send_expect(8'hD2, 1'b1, "R6 addr");
        send_expect(8'h00, 1'b1, "R6 cmd");
        send_expect(8'h00, 1'b1, "R6 count");
        send_expect(8'h33, 1'b1, "R6 d0");
        exp_r[0] = 8'h33;
        chk(cfg_regs == exp_flat(), "R6 before repeated start", 64'(cfg_regs), 64'(exp_flat()));
        bus_start();
        send_expect(8'hD2, 1'b1, "R6 addr again");
        send_expect(8'h44, 1'b1, "R6 cmd again");
        send_expect(8'h55, 1'b1, "R6 count again");
        send_expect(8'h66, 1'b1, "R6 d0 again");
        send_expect(8'h99, 1'b1, "R6 d1 again");
        bus_stop();
        exp_r[0] = 8'h66; exp_r[1] = 8'h99;
        chk(cfg_regs == exp_flat(), "R6 R4 after repeated start", 64'(cfg_regs), 64'(exp_flat()));

        // R7: bytes past the tenth are acknowledged and dropped
        bus_start();
        send_expect(8'hD2, 1'b1, "R7 addr");
        send_expect(8'h00, 1'b1, "R7 cmd");
        send_expect(8'h00, 1'b1, "R7 count");
        for (int k = 0; k < ND; k++) begin
            send_expect(8'hA0 + 8'(k), 1'b1, "R7 data ack");
            exp_r[k] = 8'hA0 + 8'(k);
        end
        send_expect(8'h0F, 1'b1, "R7 extra ack");
        send_expect(8'hF0, 1'b1, "R7 extra ack");
        bus_stop();
        chk(cfg_regs == exp_flat(), "R7 extras discarded", 64'(cfg_regs), 64'(exp_flat()));

        // R8: output gating (regs 0,1 = A0,A1 -> out_en = 16'hA1A0)
        oe_pin = 1'b1; wait_c(2);
        chk(out_en == 16'hA1A0, "R8 pin on", 64'(out_en), 64'h A1A0);
        oe_pin = 1'b0; wait_c(2);
        chk(out_en == 16'h0000, "R8 pin off", 64'(out_en), 64'h0);
        oe_pin = 1'b1;

        // R1: reset mid-operation restores all ones
        rst_n = 1'b0; wait_c(3);
        rst_n = 1'b1; wait_c(3);
        for (int k = 0; k < ND; k++) exp_r[k] = 8'hFF;
        chk(cfg_regs == exp_flat(), "R1 regs after second reset", 64'(cfg_regs), 64'(exp_flat()));
        chk(out_en == 16'hFFFF, "R1 R8 outputs enabled after reset", 64'(out_en), 64'hFFFF);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule